// File: doc/BRIEF.md
# LAPB Send Window and Retransmission Controller

This block holds the transmit-side sequence state of a LAPB-style data link. It keeps the send state variable V(S), which is the number the next new information frame will carry. It also keeps V(A), the oldest frame not yet acknowledged. Both are kept modulo 8. It decides, cycle by cycle, whether the framer may start another information frame. That decision compares the number of outstanding frames with a programmable window size.

Acknowledgement numbers N(R) arrive from the receive side, each tagged as a normal acknowledgement or a reject. The block checks each one against the current window and moves V(A) forward. Each time the window advances, it raises a block-acknowledged pulse for the host.

An acknowledgement timer watches for silence from the peer. When the timer runs out, the block commands a retransmission from V(A) and counts the attempt. When the count reaches a programmable limit, it declares the link failed. Framing, CRC and buffer handling belong to neighbouring blocks.

Top module: `lapb_send_window`

## Requirements
- R1: While `rst_n` is low and after it is released, V(S) and V(A) are 0. The retry count is 0 and the acknowledgement timer is stopped. `retx_cmd`, `blk_ack_irq`, `proto_err` and `link_fail` are all low.
- R2: `send_grant` is high in a cycle exactly when all of these hold: `send_req` is high, the window is open, `link_fail` is low, `ack_valid` is low, and the timer is not expiring in that cycle. `send_seq` always shows V(S). A grant advances V(S) by 1 modulo 8 at the next clock edge.
- R3: The outstanding count is (V(S) − V(A)) mod 8. The window is open only while that count is below `cfg_window`, which must be set between 1 and 7.
- R4: An acknowledgement is valid when (N(R) − V(A)) mod 8 ≤ (V(S) − V(A)) mod 8. A valid one sets V(A) to N(R). If N(R) differs from the old V(A), `blk_ack_irq` pulses high for one cycle after that edge.
- R5: An invalid N(R) pulses `proto_err` for one cycle after the edge. It leaves V(S), V(A) and the retry count unchanged. `proto_err` and `blk_ack_irq` are never high together.
- R6: A grant made while the timer is stopped starts it. A valid acknowledgement restarts the timer if (old V(S) − N(R)) mod 8 is nonzero, and stops it otherwise. A running timer expires in its `cfg_ack_time`-th cycle of running (`cfg_ack_time` ≥ 1). A valid acknowledgement in the same cycle overrides the expiry.
- R7: On expiry below the limit, the retry count increases by 1 and V(S) is set back to V(A). `retx_cmd` pulses one cycle after the edge, with `retx_from` equal to V(A). The timer restarts.
- R8: On an expiry that brings the retry count to `cfg_retry_limit` (≥ 1), `link_fail` goes high instead and stays high until reset. No retransmit is commanded and the timer stops. While failed, grants are refused and acknowledgements are ignored: no pulse and no state change.
- R9: A valid acknowledgement with `ack_is_rej` = 1 (reject) also sets V(S) to N(R). It pulses `retx_cmd` with `retx_from` = N(R) at once, without waiting for the timer. `ack_is_rej` = 0 marks a plain acknowledgement.
- R10: A valid acknowledgement that moves V(A) clears the retry count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_window | input | 3 | Window size K, 1 to 7 |
| cfg_retry_limit | input | 8 | Retransmission attempt limit N2, at least 1 |
| cfg_ack_time | input | 16 | Acknowledgement timeout in clock cycles, at least 1 |
| send_req | input | 1 | Framer wants to send a new information frame |
| send_grant | output | 1 | New frame may go out now, numbered send_seq |
| send_seq | output | 3 | Current V(S) |
| ack_valid | input | 1 | An N(R) is presented this cycle |
| ack_nr | input | 3 | Received N(R) |
| ack_is_rej | input | 1 | 1 = reject frame, 0 = plain acknowledgement |
| retx_cmd | output | 1 | One-cycle retransmit command |
| retx_from | output | 3 | Sequence number the retransmission starts from |
| blk_ack_irq | output | 1 | One-cycle pulse when V(A) advances |
| proto_err | output | 1 | One-cycle pulse for an out-of-window N(R) |
| link_fail | output | 1 | Retry limit reached; sticky until reset |

## Verification
The window logic is driven with back-to-back send requests against several window sizes. This shows whether the block stops at exactly K outstanding frames or lets one frame too many or too few through. Acknowledgements are drawn mostly inside the window, with some at random. This separates the in-window cases that move V(A) from the out-of-window cases that must only raise a protocol error.

Rejects are mixed in as well, to show whether the rewind comes from N(R) or from V(A). Idle stretches let the timer run out. They show whether the timeout length is exact, and whether the retry count is cleared by progress but grows on repeated silence until the link fails.

// File: rtl/lapb_sw_pkg.sv
package lapb_sw_pkg;
    localparam int SEQ_W = 3;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef struct packed {
        seq_t vs;
        seq_t va;
        logic retx;
        seq_t retx_from;
        logic blk_ack;
        logic perr;
        logic fail;
    } sw_state_t;
endpackage

// File: rtl/lapb_sw_seqcalc.sv
module lapb_sw_seqcalc
    import lapb_sw_pkg::*;
(
    input  seq_t vs,
    input  seq_t va,
    input  seq_t nr,
    input  seq_t win,
    output seq_t outstanding,
    output logic window_open,
    output logic nr_valid,
    output logic nr_moves,
    output seq_t left_after
);
    seq_t span;

    always_comb begin
        outstanding = vs - va;
        span        = nr - va;
        nr_valid    = (span <= outstanding);
        nr_moves    = (nr != va);
        left_after  = vs - nr;
        window_open = (outstanding < win);
    end
endmodule

// File: rtl/lapb_sw_acktimer.sv
module lapb_sw_acktimer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TMR_W-1:0] limit,
    input  logic             start_idle,
    input  logic             restart,
    input  logic             halt,
    output logic             expire
);
    typedef struct packed {
        logic             run;
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (halt) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (restart) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (start_idle && !tmr_q.run) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (tmr_q.run) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        expire = tmr_q.run && (tmr_q.cnt == limit - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R6: an undisturbed running timer advances by one each cycle
    assert_timer_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.run && !halt && !restart && !expire) |=> (tmr_q.cnt == $past(tmr_q.cnt) + 1'b1));

    // R6: a halted timer is idle on the next cycle
    assert_timer_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !tmr_q.run);
endmodule

// File: rtl/lapb_sw_retry.sv
module lapb_sw_retry #(
    parameter int RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RETRY_W-1:0] limit,
    input  logic               bump,
    input  logic               clear,
    output logic               hit_on_bump
);
    logic [RETRY_W-1:0] cnt_d, cnt_q;
    logic [RETRY_W:0]   cnt_inc;

    always_comb begin
        cnt_inc     = {1'b0, cnt_q} + 1'b1;
        hit_on_bump = (cnt_inc >= {1'b0, limit});
        cnt_d       = cnt_q;
        if (clear)     cnt_d = '0;
        else if (bump) cnt_d = cnt_inc[RETRY_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: each expiry adds exactly one attempt
    assert_retry_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && !clear) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R10: progress empties the counter
    assert_retry_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/lapb_send_window.sv
module lapb_send_window
    import lapb_sw_pkg::*;
#(
    parameter int TMR_W   = 16,
    parameter int RETRY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SEQ_W-1:0]   cfg_window,
    input  logic [RETRY_W-1:0] cfg_retry_limit,
    input  logic [TMR_W-1:0]   cfg_ack_time,
    input  logic               send_req,
    output logic               send_grant,
    output logic [SEQ_W-1:0]   send_seq,
    input  logic               ack_valid,
    input  logic [SEQ_W-1:0]   ack_nr,
    input  logic               ack_is_rej,
    output logic               retx_cmd,
    output logic [SEQ_W-1:0]   retx_from,
    output logic               blk_ack_irq,
    output logic               proto_err,
    output logic               link_fail
);
    sw_state_t st_d, st_q;

    seq_t outstanding, left_after;
    logic window_open, nr_valid, nr_moves;
    logic expire, hit_on_bump;
    logic t_start, t_restart, t_halt;
    logic r_bump, r_clear;

    lapb_sw_seqcalc u_calc (
        .vs          (st_q.vs),
        .va          (st_q.va),
        .nr          (ack_nr),
        .win         (cfg_window),
        .outstanding (outstanding),
        .window_open (window_open),
        .nr_valid    (nr_valid),
        .nr_moves    (nr_moves),
        .left_after  (left_after)
    );

    lapb_sw_acktimer #(.TMR_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .limit      (cfg_ack_time),
        .start_idle (t_start),
        .restart    (t_restart),
        .halt       (t_halt),
        .expire     (expire)
    );

    lapb_sw_retry #(.RETRY_W(RETRY_W)) u_retry (
        .clk         (clk),
        .rst_n       (rst_n),
        .limit       (cfg_retry_limit),
        .bump        (r_bump),
        .clear       (r_clear),
        .hit_on_bump (hit_on_bump)
    );

    always_comb begin
        st_d         = st_q;
        st_d.retx    = 1'b0;
        st_d.blk_ack = 1'b0;
        st_d.perr    = 1'b0;
        t_start      = 1'b0;
        t_restart    = 1'b0;
        t_halt       = 1'b0;
        r_bump       = 1'b0;
        r_clear      = 1'b0;
        send_grant   = send_req && window_open && !st_q.fail && !ack_valid && !expire;

        if (!st_q.fail) begin
            if (ack_valid && nr_valid) begin
                st_d.va = ack_nr;
                if (nr_moves) begin
                    st_d.blk_ack = 1'b1;
                    r_clear      = 1'b1;
                end
                if (left_after != '0) t_restart = 1'b1;
                else                  t_halt    = 1'b1;
                if (ack_is_rej) begin
                    st_d.vs        = ack_nr;
                    st_d.retx      = 1'b1;
                    st_d.retx_from = ack_nr;
                end
            end else begin
                if (ack_valid) st_d.perr = 1'b1;
                if (expire) begin
                    r_bump = 1'b1;
                    if (hit_on_bump) begin
                        st_d.fail = 1'b1;
                        t_halt    = 1'b1;
                    end else begin
                        st_d.retx      = 1'b1;
                        st_d.retx_from = st_q.va;
                        st_d.vs        = st_q.va;
                        t_restart      = 1'b1;
                    end
                end else if (send_grant) begin
                    st_d.vs = st_q.vs + 1'b1;
                    t_start = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign send_seq    = st_q.vs;
    assign retx_cmd    = st_q.retx;
    assign retx_from   = st_q.retx_from;
    assign blk_ack_irq = st_q.blk_ack;
    assign proto_err   = st_q.perr;
    assign link_fail   = st_q.fail;

    // R3: a grant never pushes the outstanding count beyond K
    assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        send_grant |=> (outstanding <= cfg_window));

    // R8: once failed, the link stays failed
    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail |=> link_fail);

    // R7: a retransmission leaves V(S) at its starting number
    assert_retx_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retx_cmd |-> (send_seq == retx_from));

    // R5: error and acknowledge pulses exclude each other
    assert_irq_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(proto_err && blk_ack_irq));

    // R5: a rejected N(R) leaves V(A) untouched
    assert_perr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (st_q.va == $past(st_q.va)));
endmodule

// File: tb/tb_lapb_send_window.sv
`timescale 1ns/100ps
module tb_lapb_send_window;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_window = 3'd3;
    logic [7:0] cfg_retry_limit = 8'd3;
    logic [15:0] cfg_ack_time = 16'd8;
    logic       send_req = 1'b0;
    logic       send_grant;
    logic [2:0] send_seq;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_nr = 3'd0;
    logic       ack_is_rej = 1'b0;
    logic       retx_cmd;
    logic [2:0] retx_from;
    logic       blk_ack_irq, proto_err, link_fail;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    int m_vs, m_va, m_cnt, m_retry, m_from;
    bit m_run, m_fail, m_retx, m_blk, m_perr;

    always #2.5 clk = ~clk;

    lapb_send_window dut (
        .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window),
        .cfg_retry_limit(cfg_retry_limit), .cfg_ack_time(cfg_ack_time),
        .send_req(send_req), .send_grant(send_grant), .send_seq(send_seq),
        .ack_valid(ack_valid), .ack_nr(ack_nr), .ack_is_rej(ack_is_rej),
        .retx_cmd(retx_cmd), .retx_from(retx_from), .blk_ack_irq(blk_ack_irq),
        .proto_err(proto_err), .link_fail(link_fail)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_grant(bit req, bit av);
        int out;
        bit expire;
        out    = (m_vs - m_va) & 7;
        expire = m_run && (m_cnt == int'(cfg_ack_time) - 1);
        return req && (out < int'(cfg_window)) && !m_fail && !av && !expire;
    endfunction

    task automatic model_reset();
        m_vs = 0; m_va = 0; m_cnt = 0; m_retry = 0; m_from = 0;
        m_run = 0; m_fail = 0; m_retx = 0; m_blk = 0; m_perr = 0;
    endtask

    task automatic check_outputs();
        chk("R2 send_seq", send_seq, m_vs);
        chk("R7 R9 retx_cmd", retx_cmd, m_retx);
        if (m_retx) chk("R7 R9 retx_from", retx_from, m_from);
        chk("R4 blk_ack_irq", blk_ack_irq, m_blk);
        chk("R5 proto_err", proto_err, m_perr);
        chk("R8 link_fail", link_fail, m_fail);
    endtask

    task automatic step(bit req, bit av, int nr, bit rej);
        bit g, expire, valid, st, rs, hl;
        int out;
        check_outputs();
        send_req = req; ack_valid = av; ack_nr = 3'(nr); ack_is_rej = rej;
        #1;
        g = exp_grant(req, av);
        chk("R2 R3 send_grant", send_grant, g);
        out    = (m_vs - m_va) & 7;
        expire = m_run && (m_cnt == int'(cfg_ack_time) - 1);
        valid  = av && (((nr - m_va) & 7) <= out);
        m_retx = 0; m_blk = 0; m_perr = 0;
        st = 0; rs = 0; hl = 0;
        if (!m_fail) begin
            if (valid) begin
                if (nr != m_va) begin m_blk = 1; m_retry = 0; end
                if (((m_vs - nr) & 7) != 0) rs = 1; else hl = 1;
                if (rej) begin m_vs = nr; m_retx = 1; m_from = nr; end
                m_va = nr;
            end else begin
                if (av) m_perr = 1;
                if (expire) begin
                    m_retry++;
                    if (m_retry >= int'(cfg_retry_limit)) begin m_fail = 1; hl = 1; end
                    else begin m_retx = 1; m_from = m_va; m_vs = m_va; rs = 1; end
                end else if (g) begin
                    m_vs = (m_vs + 1) & 7; st = 1;
                end
            end
        end
        if (hl) begin m_run = 0; m_cnt = 0; end
        else if (rs) begin m_run = 1; m_cnt = 0; end
        else if (st && !m_run) begin m_run = 1; m_cnt = 0; end
        else if (m_run) m_cnt++;
        @(negedge clk);
    endtask

    task automatic do_reset(int k, int n2, int t);
        rst_n = 1'b0;
        send_req = 0; ack_valid = 0; ack_is_rej = 0;
        cfg_window = 3'(k); cfg_retry_limit = 8'(n2); cfg_ack_time = 16'(t);
        repeat (3) @(negedge clk);
        chk("R1 send_seq in reset", send_seq, 0);
        chk("R1 link_fail in reset", link_fail, 0);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        #(5.0 * 200000);
        n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int wait_n;
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset(3, 2, 8);
        check_outputs(); // R1 state right after release

        // R3: window of 3 fills, fourth request refused
        repeat (4) step(1, 0, 0, 0);
        // R4: acknowledge two frames
        step(0, 1, 2, 0);
        // R5: N(R) beyond V(S)
        step(0, 1, 6, 0);
        // R9: reject from 2
        step(0, 1, 2, 1);
        step(0, 0, 0, 0);

        // R6: exact timeout length after a fresh start
        do_reset(2, 2, 8);
        step(1, 0, 0, 0);
        wait_n = 0;
        while (!retx_cmd && wait_n < 50) begin
            step(0, 0, 0, 0);
            wait_n++;
        end
        chk("R6 timeout cycles", wait_n, 8);
        // R10: progress clears the retry count, next expiry is not fatal
        step(1, 0, 0, 0);
        step(0, 1, 1, 0);
        step(1, 0, 0, 0);
        repeat (10) step(0, 0, 0, 0);
        chk("R10 no failure after cleared count", link_fail, 0);
        // R8: second silent expiry fails the link
        repeat (10) step(0, 0, 0, 0);
        chk("R8 link failed", link_fail, 1);
        step(1, 1, 3, 0);
        step(1, 0, 0, 0);
        step(0, 0, 0, 0);

        // randomized phases
        for (int ph = 0; ph < 8; ph++) begin
            do_reset(1 + ($urandom % 7), 1 + ($urandom % 5), 1 + ($urandom % 20));
            for (int i = 0; i < 2500; i++) begin
                int r, out, nr;
                bit av, rej;
                r   = $urandom % 100;
                out = (m_vs - m_va) & 7;
                av  = (r < 25);
                if (($urandom % 100) < 15) nr = $urandom % 8;
                else                       nr = (m_va + ($urandom % (out + 1))) & 7;
                rej = (($urandom % 100) < 20);
                step(($urandom % 100) < 60, av, nr, rej);
            end
        end

        check_outputs();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule